// File: doc/BRIEF.md
# Crossroad Light Controller with Side-Road Detection

This block sequences the signal lights at a junction where a busy main road crosses a quiet side road. While the side-road vehicle detector reports nothing, the main road keeps green and the side road keeps red. When a vehicle is waiting on the side road, the main road stays green for a fixed number of seconds and then drops through yellow to red. The side road then gets a fixed green interval whether or not traffic remains. It ends with its own yellow, and the main road takes over again.

Time is measured in whole seconds. An external one-cycle-per-second enable (`sec_tick`) is supplied by the surrounding chip. A phase state machine walks four phases: main green, main yellow, side green, side yellow. A seconds counter restarts at every phase entry, and both light codes are decoded from the phase into registers. All durations are parameters. The defaults are 40 s main green, 20 s side green and 4 s yellow.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst_n` is low, the lights go to main green and side red on the next clock edge. After release the controller starts in main green with its seconds count at zero.
- R2: With `side_car` low, the main light stays green (2'b00) and the side light stays red (2'b11) for any number of ticks.
- R3: With `side_car` held high, the main light stays green for exactly MAIN_GREEN_S ticks counted from entry to main green. The main light then changes to yellow while the side light stays red.
- R4: The main yellow (2'b01) lasts exactly YELLOW_S ticks with the side light red. The main light then turns red and the side light turns green.
- R5: The side green lasts exactly SIDE_GREEN_S ticks whatever the level of `side_car` during that time.
- R6: The side yellow lasts exactly YELLOW_S ticks with the main light red. The controller then returns to main green and side red.
- R7: If `side_car` is low on any cycle of main green, the seconds count restarts. A full MAIN_GREEN_S ticks of continuous detection are then needed before the main light leaves green.
- R8: The seconds count advances only on cycles with `sec_tick` high. Without ticks, no light changes.
- R9: Light codes are green 2'b00, yellow 2'b01 and red 2'b11, and no other value appears. At every cycle at least one of the two roads shows red.
- R10: Each light output is registered. It changes on the clock edge after the edge at which the completing tick is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| side_car | input | 1 | Side-road vehicle detector, high while a vehicle waits |
| main_light | output | 2 | Main road light code (00 green, 01 yellow, 11 red) |
| side_light | output | 2 | Side road light code (00 green, 01 yellow, 11 red) |

## Verification
The bench builds the block with 6 s main green, 4 s side green and 2 s yellow. At these values a complete four-phase rotation takes 14 ticks, so many full rotations fit in a short run. The bench drives ticks on every cycle in some stretches and on every third cycle in others. This exposes off-by-one duration errors and any advance without a tick. The short main green also makes a detector drop a few seconds into the phase easy to reach, along with the full restart that must follow it. A long run without ticks inside side green shows that the lights hold.

// File: rtl/xroad_pkg.sv
// Package xroad_pkg
// Purpose : shared phase type and light codes for the crossroad light controller.
// Assumes : the two light roads share one code set; phase order is the rotation order.
package xroad_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_SLOW = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_SLOW = 2'd3
    } phase_t;

    localparam logic [1:0] LAMP_GREEN  = 2'b00;
    localparam logic [1:0] LAMP_YELLOW = 2'b01;
    localparam logic [1:0] LAMP_RED    = 2'b11;

    localparam int NUM_ROADS = 2;

endpackage

// File: rtl/xroad_sec_timer.sv
// Module xroad_sec_timer
// Purpose : counts elapsed seconds within the current phase.
// Assumes : clear has priority over tick; the phase machine clears the
//           count before it can exceed the longest phase duration.
module xroad_sec_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    // Seconds count: restart on clear, step on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/xroad_phase_fsm.sv
// Module xroad_phase_fsm
// Purpose : walks main green, main yellow, side green, side yellow.
//           Main green is held until the detector has been high for
//           MAIN_GREEN_S ticks in a row; every other phase lasts a fixed
//           number of ticks.
// Assumes : count comes from xroad_sec_timer and is cleared via restart.
module xroad_phase_fsm
    import xroad_pkg::*;
#(
    parameter int MAIN_GREEN_S = 40,
    parameter int YELLOW_S     = 4,
    parameter int SIDE_GREEN_S = 20,
    parameter int CNT_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             car,
    input  logic [CNT_W-1:0] count,
    output phase_t           phase,
    output logic             restart
);

    localparam logic [CNT_W-1:0] MG_LAST = CNT_W'(MAIN_GREEN_S - 1);
    localparam logic [CNT_W-1:0] YL_LAST = CNT_W'(YELLOW_S - 1);
    localparam logic [CNT_W-1:0] SG_LAST = CNT_W'(SIDE_GREEN_S - 1);

    logic [CNT_W-1:0] last_sec;
    logic             at_end;
    logic             advance;
    logic             waiting;
    phase_t           phase_nxt;

    // Select the final second index of the current phase.
    always_comb begin
        case (phase)
            PH_MAIN_GO:   last_sec = MG_LAST;
            PH_SIDE_GO:   last_sec = SG_LAST;
            default:      last_sec = YL_LAST;
        endcase
    end

    // Decide whether this cycle completes the phase or restarts the count.
    always_comb begin
        waiting = (phase == PH_MAIN_GO) && !car;
        at_end  = tick && (count == last_sec);
        advance = at_end && !waiting;
        restart = advance || waiting;
    end

    // Rotation order of the phases.
    always_comb begin
        case (phase)
            PH_MAIN_GO:   phase_nxt = PH_MAIN_SLOW;
            PH_MAIN_SLOW: phase_nxt = PH_SIDE_GO;
            PH_SIDE_GO:   phase_nxt = PH_SIDE_SLOW;
            default:      phase_nxt = PH_MAIN_GO;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_MAIN_GO;
        end else if (advance) begin
            phase <= phase_nxt;
        end
    end

endmodule

// File: rtl/xroad_lamp_decode.sv
// Module xroad_lamp_decode
// Purpose : registered decode of the phase into one light code per road.
// Assumes : road 0 is the main road, road 1 the side road; each road owns
//           a green phase followed directly by its yellow phase.
module xroad_lamp_decode
    import xroad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  phase_t     phase,
    output logic [1:0] main_light,
    output logic [1:0] side_light
);

    logic [1:0] lamp_q [NUM_ROADS];

    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        localparam phase_t GO_PH   = (r == 0) ? PH_MAIN_GO   : PH_SIDE_GO;
        localparam phase_t SLOW_PH = (r == 0) ? PH_MAIN_SLOW : PH_SIDE_SLOW;
        localparam logic [1:0] RST_LAMP = (r == 0) ? LAMP_GREEN : LAMP_RED;

        logic [1:0] lamp_d;

        // Map the phase onto this road's light.
        always_comb begin
            if (phase == GO_PH) begin
                lamp_d = LAMP_GREEN;
            end else if (phase == SLOW_PH) begin
                lamp_d = LAMP_YELLOW;
            end else begin
                lamp_d = LAMP_RED;
            end
        end

        // Light output register for this road.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lamp_q[r] <= RST_LAMP;
            end else begin
                lamp_q[r] <= lamp_d;
            end
        end
    end

    assign main_light = lamp_q[0];
    assign side_light = lamp_q[1];

endmodule

// File: rtl/xroad_light_ctrl.sv
// Module xroad_light_ctrl
// Purpose : top of the sensor-triggered crossroad light controller.
// Assumes : sec_tick is a single-cycle pulse once per second generated
//           elsewhere; side_car is already debounced and synchronous.
module xroad_light_ctrl
    import xroad_pkg::*;
#(
    parameter int MAIN_GREEN_S = 40,
    parameter int YELLOW_S     = 4,
    parameter int SIDE_GREEN_S = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       side_car,
    output logic [1:0] main_light,
    output logic [1:0] side_light
);

    localparam int MAX_GREEN = (MAIN_GREEN_S > SIDE_GREEN_S) ? MAIN_GREEN_S : SIDE_GREEN_S;
    localparam int MAX_DUR   = (MAX_GREEN > YELLOW_S) ? MAX_GREEN : YELLOW_S;
    localparam int CNT_W     = (MAX_DUR < 2) ? 1 : $clog2(MAX_DUR);

    logic [CNT_W-1:0] sec_count;
    logic             sec_clear;
    phase_t           phase;

    xroad_sec_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (sec_clear),
        .tick  (sec_tick),
        .count (sec_count)
    );

    xroad_phase_fsm #(
        .MAIN_GREEN_S(MAIN_GREEN_S),
        .YELLOW_S    (YELLOW_S),
        .SIDE_GREEN_S(SIDE_GREEN_S),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (sec_tick),
        .car     (side_car),
        .count   (sec_count),
        .phase   (phase),
        .restart (sec_clear)
    );

    xroad_lamp_decode u_lamps (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .main_light (main_light),
        .side_light (side_light)
    );

endmodule

// File: rtl/xroad_light_ctrl_chk.sv
// Module xroad_light_ctrl_chk
// Purpose : port-level properties of the crossroad light controller.
// Assumes : bound to every instance of xroad_light_ctrl.
module xroad_light_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       side_car,
    input logic [1:0] main_light,
    input logic [1:0] side_light
);

    // R1: reset drives main green / side red on the next edge
    a_r1_reset_lamps: assert property (@(posedge clk)
        !rst_n |=> (main_light == 2'b00 && side_light == 2'b11));

    // R9: only legal codes appear
    a_r9_legal_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (main_light != 2'b10) && (side_light != 2'b10));

    // R9: at least one road is red at all times
    a_r9_one_red: assert property (@(posedge clk) disable iff (!rst_n)
        (main_light == 2'b11) || (side_light == 2'b11));

    // R3: main green can only be left towards yellow
    a_r3_main_green_to_yellow: assert property (@(posedge clk) disable iff (!rst_n)
        (main_light == 2'b00) |=> (main_light == 2'b00 || main_light == 2'b01));

    // R4: main yellow can only be left towards red
    a_r4_main_yellow_to_red: assert property (@(posedge clk) disable iff (!rst_n)
        (main_light == 2'b01) |=> (main_light == 2'b01 || main_light == 2'b11));

    // R6: side green can only be left towards yellow
    a_r6_side_green_to_yellow: assert property (@(posedge clk) disable iff (!rst_n)
        (side_light == 2'b00) |=> (side_light == 2'b00 || side_light == 2'b01));

    // R6: side yellow can only be left towards red
    a_r6_side_yellow_to_red: assert property (@(posedge clk) disable iff (!rst_n)
        (side_light == 2'b01) |=> (side_light == 2'b01 || side_light == 2'b11));

    // R8 / R10: a light change needs a tick two edges earlier
    a_r8_change_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (main_light != $past(main_light) || side_light != $past(side_light))
            |-> $past(sec_tick, 2));

endmodule

bind xroad_light_ctrl xroad_light_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .side_car   (side_car),
    .main_light (main_light),
    .side_light (side_light)
);

// File: tb/tb_xroad_light_ctrl.sv
module tb_xroad_light_ctrl;

    localparam int MG = 6;
    localparam int YS = 2;
    localparam int SG = 4;

    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic       sec_tick = 1'b0;
    logic       side_car = 1'b0;
    logic [1:0] main_light;
    logic [1:0] side_light;

    always #2 clk = ~clk;   // 250 MHz

    xroad_light_ctrl #(
        .MAIN_GREEN_S(MG),
        .YELLOW_S    (YS),
        .SIDE_GREEN_S(SG)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .side_car   (side_car),
        .main_light (main_light),
        .side_light (side_light)
    );

    typedef struct {
        logic [1:0] m;
        logic [1:0] s;
        string      tag;
    } exp_t;

    exp_t  sb[$];
    exp_t  mon_e;
    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;

    // reference model state (from the requirements)
    int         mph  = 0;
    int         mcnt = 0;
    logic [1:0] last_m = 2'b00;
    logic [1:0] last_s = 2'b11;

    function automatic int dur(input int p);
        case (p)
            0: return MG;
            2: return SG;
            default: return YS;
        endcase
    endfunction

    // R9 encoding: green 00, yellow 01, red 11
    function automatic logic [1:0] lamp(input int road, input int p);
        int go;
        go = (road == 0) ? 0 : 2;
        if (p == go) return 2'b00;
        if (p == go + 1) return 2'b01;
        return 2'b11;
    endfunction

    task automatic push(input logic [1:0] m, input logic [1:0] s, input string tag);
        exp_t e;
        e.m = m; e.s = s; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n = 1'b0; sec_tick = 1'b0; side_car = 1'b0;
            push(2'b00, 2'b11, "R1");
        end
        mph = 0; mcnt = 0; last_m = 2'b00; last_s = 2'b11;
    endtask

    // driver: one cycle of stimulus plus its expected light pair
    task automatic step(input bit t, input bit c, input string tag);
        string      tg;
        logic [1:0] em, es;
        @(negedge clk);
        rst_n = 1'b1; sec_tick = t; side_car = c;
        em = lamp(0, mph);
        es = lamp(1, mph);
        if (tag != "") tg = tag;
        else begin
            case (mph)
                0: tg = "R3";
                1: tg = "R4/R9";
                2: tg = "R5";
                default: tg = "R6";
            endcase
        end
        if (em != last_m || es != last_s) tg = {tg, " R10"};
        push(em, es, tg);
        last_m = em; last_s = es;
        if (mph == 0 && !c) mcnt = 0;
        else if (t) begin
            if (mcnt == dur(mph) - 1) begin
                mph  = (mph + 1) % 4;
                mcnt = 0;
            end else begin
                mcnt = mcnt + 1;
            end
        end
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            mon_e = sb.pop_front();
            checks++;
            if (main_light !== mon_e.m || side_light !== mon_e.s) begin
                fails++;
                $display("FAIL %s main=%b exp=%b side=%b exp=%b t=%0t",
                         mon_e.tag, main_light, mon_e.m, side_light, mon_e.s, $time);
            end
        end
    end

    initial begin
        do_reset(3);                               // R1
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0, "R2");
        // full rotations with ticks every cycle: R3 R4 R5 R6 R10
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, "");
        while (!(mph == 0 && mcnt == 0)) step(1'b1, 1'b1, "");
        // R7: drop detector part way into main green
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");
        step(1'b1, 1'b0, "R7");
        for (int i = 0; i < MG; i++) step(1'b1, 1'b1, "R7");
        while (!(mph == 0 && mcnt == 0)) step(1'b1, 1'b1, "");
        // R5: detector gone during side green
        while (mph != 2) step(1'b1, 1'b1, "");
        while (mph != 0) step(1'b1, 1'b0, "R5");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R2");
        // R8: no ticks inside side green, detector toggling
        while (mph != 2) step(1'b1, 1'b1, "");
        for (int i = 0; i < 12; i++) step(1'b0, (i % 2) == 0, "R8");
        // slow ticks, every third cycle
        for (int i = 0; i < 90; i++) step((i % 3) == 0, 1'b1, "");
        // R8: no ticks in main green with car present
        while (!(mph == 0)) step(1'b1, 1'b1, "");
        for (int i = 0; i < 20; i++) step(1'b0, 1'b1, "R8");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "");
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired at t=%0t", $time);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule